// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block holds the configuration bytes of a PCI IDE function that govern where its two ATA channels appear in I/O space. From them it derives, for each channel, an enable, an 8-byte command-block base, a single control-port address and an 8-byte bus-master register base. A global bus-master enable is also produced. Each channel can sit at its fixed legacy addresses or at addresses taken from its own base registers, and the two channels make this choice independently.

The block also decodes an incoming 16-bit I/O address against every window. It reports a per-channel hit for the command block, the control port and the bus-master block, so that the surrounding function can claim the cycle. Configuration writes arrive as single bytes on a simple write strobe. A combinational read port returns the stored value of any byte the block implements. A status byte latches event pulses from the channel logic, and software clears it through configuration writes.

Top module: `ide_addr_decoder`

## Requirements
- R1: After reset, offset 0x4A reads 0x06. Offsets 0x04, 0x07, 0x09 and every base-register byte read 0x00. `ch_en` and `bm_en` are 0.
- R2: Channel 0 (primary) is enabled exactly when bit 0 of offset 0x04 and bit 2 of offset 0x4A are both 1. Channel 1 (secondary) is enabled exactly when bit 0 of 0x04 and bit 1 of 0x4A are both 1.
- R3: Writes are masked before storage: offset 0x04 keeps only the bits of 0x05, offset 0x09 keeps only the bits of 0xCF, and offset 0x4A keeps only the bits of 0xAF. Readback returns the masked value.
- R4: When bit 0 of 0x09 (primary) or bit 2 of 0x09 (secondary) is 0, that channel uses its legacy addresses. For the primary channel these are command base 0x01F0 and control 0x03F6. For the secondary channel they are 0x0170 and 0x0376.
- R5: When the channel's native bit is 1, its command base is the 16-bit value at offsets 0x10/0x11 (primary) or 0x18/0x19 (secondary), low byte first, with bits 2:0 forced to 0.
- R6: When the channel's native bit is 1, its control address is the 16-bit value at 0x14/0x15 (primary) or 0x1C/0x1D (secondary) with bits 1:0 forced to 0, plus 2, taken modulo 2^16.
- R7: The primary bus-master base is the 16-bit value at 0x20/0x21 with bits 3:0 forced to 0. The secondary bus-master base is that value plus 8. `bm_en` equals bit 2 of offset 0x04.
- R8: A write to offset 0x07 replaces the status byte with the old value AND the written byte, so bits written 0 clear. Each cycle, `sts_set` bits are ORed in, and a set in the same cycle as a write survives it.
- R9: `hit_cmd[c]` is 1 when channel c is enabled and the I/O address lies within the 8 bytes from its command base. `hit_ctl[c]` is 1 when channel c is enabled and the address equals its control address. `hit_bm[c]` is 1 when `bm_en` is 1 and the address lies within the 8 bytes from channel c's bus-master base.
- R10: A configuration write changes the outputs starting in the cycle after the clock edge that captured it. Hits and read data follow their inputs combinationally.
- R11: Writes to offsets other than 0x04, 0x07, 0x09, 0x10, 0x11, 0x14, 0x15, 0x18, 0x19, 0x1C, 0x1D, 0x20, 0x21 and 0x4A change nothing, and such offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset for write and read |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored value at `cfg_addr` (combinational) |
| sts_set | input | 8 | Status event pulses, ORed into the status byte |
| io_addr | input | 16 | I/O address to decode |
| ch_en | output | 2 | Channel enables, bit 0 primary |
| pri_cmd_base | output | 16 | Primary command-block base |
| pri_ctl_addr | output | 16 | Primary control-port address |
| sec_cmd_base | output | 16 | Secondary command-block base |
| sec_ctl_addr | output | 16 | Secondary control-port address |
| pri_bm_base | output | 16 | Primary bus-master block base |
| sec_bm_base | output | 16 | Secondary bus-master block base |
| bm_en | output | 1 | Bus-master decode enable |
| hit_cmd | output | 2 | Command-block hit per channel |
| hit_ctl | output | 2 | Control-port hit per channel |
| hit_bm | output | 2 | Bus-master block hit per channel |

## Verification
Every stored byte sits one register stage behind `cfg_we`. A write applied at a falling edge is captured at the next rising edge, and its enables and addresses are sampled at the falling edge after that. One probe samples just before that rising edge to confirm the old value still holds. Read data and all hit outputs are combinational from the stored bytes, so the bench changes `cfg_addr` or `io_addr` at a falling edge and samples 1 ns later, well before the next rising edge. Status pulses follow the same one-cycle rule as writes.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int IO_W   = 16;
  localparam int CFG_AW = 8;
  localparam int NCH    = 2;

  localparam logic [CFG_AW-1:0] OFS_CMD     = 8'h04;
  localparam logic [CFG_AW-1:0] OFS_STS     = 8'h07;
  localparam logic [CFG_AW-1:0] OFS_PI      = 8'h09;
  localparam logic [CFG_AW-1:0] OFS_P_CMD   = 8'h10;
  localparam logic [CFG_AW-1:0] OFS_P_CTL   = 8'h14;
  localparam logic [CFG_AW-1:0] OFS_S_CMD   = 8'h18;
  localparam logic [CFG_AW-1:0] OFS_S_CTL   = 8'h1C;
  localparam logic [CFG_AW-1:0] OFS_BM      = 8'h20;
  localparam logic [CFG_AW-1:0] OFS_CHCTL   = 8'h4A;

  localparam logic [7:0] MSK_CMD   = 8'h05;
  localparam logic [7:0] MSK_PI    = 8'hCF;
  localparam logic [7:0] MSK_CHCTL = 8'hAF;
  localparam logic [7:0] RST_CHCTL = 8'h06;

  localparam int BLK_SPAN = 8;

  // bit of the channel-control byte that turns channel ch on
  function automatic int chan_on_bit(input int ch);
    return 2 - ch;
  endfunction

  // bit of the programming-interface byte that selects native mode
  function automatic int native_bit(input int ch);
    return 2 * ch;
  endfunction

  function automatic logic [IO_W-1:0] legacy_cmd(input int ch);
    return (ch == 0) ? IO_W'(16'h01F0) : IO_W'(16'h0170);
  endfunction

  function automatic logic [IO_W-1:0] legacy_ctl(input int ch);
    return (ch == 0) ? IO_W'(16'h03F6) : IO_W'(16'h0376);
  endfunction

  function automatic logic [IO_W-1:0] native_cmd(input logic [IO_W-1:0] bar);
    return {bar[IO_W-1:3], 3'b000};
  endfunction

  function automatic logic [IO_W-1:0] native_ctl(input logic [IO_W-1:0] bar);
    return {bar[IO_W-1:2], 2'b00} + IO_W'(2);
  endfunction

  function automatic logic [IO_W-1:0] bm_chan_base(input logic [IO_W-1:0] bar, input int ch);
    return {bar[IO_W-1:4], 4'b0000} + IO_W'(ch * BLK_SPAN);
  endfunction

  // true when addr falls inside the aligned 8-byte block starting at base
  function automatic logic in_block(input logic [IO_W-1:0] addr, input logic [IO_W-1:0] base);
    return addr[IO_W-1:3] == base[IO_W-1:3];
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  input  logic [7:0]                   sts_set,
  output logic [7:0]                   cfg_rdata,
  output logic [7:0]                   cmd_q,
  output logic [7:0]                   pi_q,
  output logic [7:0]                   chctl_q,
  output logic [7:0]                   sts_q,
  output logic [NCH-1:0][IO_W-1:0]     cmd_bar_q,
  output logic [NCH-1:0][IO_W-1:0]     ctl_bar_q,
  output logic [IO_W-1:0]              bm_bar_q
);
  localparam int NB = IO_W / 8;

  logic wr_sts;
  assign wr_sts = cfg_we && (cfg_addr == OFS_STS);

  // offset of byte b of a 16-bit base register
  function automatic logic [CFG_AW-1:0] ofs_byte(input logic [CFG_AW-1:0] base, input int b);
    return base + CFG_AW'(b);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      pi_q    <= '0;
      chctl_q <= RST_CHCTL;
      sts_q   <= '0;
    end else begin
      sts_q <= (wr_sts ? (sts_q & cfg_wdata) : sts_q) | sts_set;
      if (cfg_we) begin
        unique case (cfg_addr)
          OFS_CMD:   cmd_q   <= cfg_wdata & MSK_CMD;
          OFS_PI:    pi_q    <= cfg_wdata & MSK_PI;
          OFS_CHCTL: chctl_q <= cfg_wdata & MSK_CHCTL;
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bar_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd_bar_q[0][8*b +: 8] <= '0;
        cmd_bar_q[1][8*b +: 8] <= '0;
        ctl_bar_q[0][8*b +: 8] <= '0;
        ctl_bar_q[1][8*b +: 8] <= '0;
        bm_bar_q[8*b +: 8]     <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ofs_byte(OFS_P_CMD, b)) cmd_bar_q[0][8*b +: 8] <= cfg_wdata;
        if (cfg_addr == ofs_byte(OFS_S_CMD, b)) cmd_bar_q[1][8*b +: 8] <= cfg_wdata;
        if (cfg_addr == ofs_byte(OFS_P_CTL, b)) ctl_bar_q[0][8*b +: 8] <= cfg_wdata;
        if (cfg_addr == ofs_byte(OFS_S_CTL, b)) ctl_bar_q[1][8*b +: 8] <= cfg_wdata;
        if (cfg_addr == ofs_byte(OFS_BM, b))    bm_bar_q[8*b +: 8]     <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_CMD:               cfg_rdata = cmd_q;
      OFS_STS:               cfg_rdata = sts_q;
      OFS_PI:                cfg_rdata = pi_q;
      OFS_CHCTL:             cfg_rdata = chctl_q;
      ofs_byte(OFS_P_CMD,0): cfg_rdata = cmd_bar_q[0][7:0];
      ofs_byte(OFS_P_CMD,1): cfg_rdata = cmd_bar_q[0][15:8];
      ofs_byte(OFS_S_CMD,0): cfg_rdata = cmd_bar_q[1][7:0];
      ofs_byte(OFS_S_CMD,1): cfg_rdata = cmd_bar_q[1][15:8];
      ofs_byte(OFS_P_CTL,0): cfg_rdata = ctl_bar_q[0][7:0];
      ofs_byte(OFS_P_CTL,1): cfg_rdata = ctl_bar_q[0][15:8];
      ofs_byte(OFS_S_CTL,0): cfg_rdata = ctl_bar_q[1][7:0];
      ofs_byte(OFS_S_CTL,1): cfg_rdata = ctl_bar_q[1][15:8];
      ofs_byte(OFS_BM,0):    cfg_rdata = bm_bar_q[7:0];
      ofs_byte(OFS_BM,1):    cfg_rdata = bm_bar_q[15:8];
      default:               cfg_rdata = '0;
    endcase
  end

  AST_CHCTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CHCTL) |=> (chctl_q == ($past(cfg_wdata) & MSK_CHCTL))); // R3
  AST_CMD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~MSK_CMD) == 8'h00); // R3
  AST_STS_WRITE_AND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts |=> (sts_q == (($past(sts_q) & $past(cfg_wdata)) | $past(sts_set)))); // R8
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> (sts_q == ($past(sts_q) | $past(sts_set)))); // R8
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_en,
  input  logic            chan_on,
  input  logic            native,
  input  logic            bm_en,
  input  logic [IO_W-1:0] cmd_bar,
  input  logic [IO_W-1:0] ctl_bar,
  input  logic [IO_W-1:0] bm_bar,
  input  logic [IO_W-1:0] io_addr,
  output logic            en,
  output logic [IO_W-1:0] cmd_base,
  output logic [IO_W-1:0] ctl_addr,
  output logic [IO_W-1:0] bm_base,
  output logic            hit_cmd,
  output logic            hit_ctl,
  output logic            hit_bm
);
  assign en       = io_en && chan_on;
  assign cmd_base = native ? native_cmd(cmd_bar) : legacy_cmd(CH);
  assign ctl_addr = native ? native_ctl(ctl_bar) : legacy_ctl(CH);
  assign bm_base  = bm_chan_base(bm_bar, CH);

  assign hit_cmd = en && in_block(io_addr, cmd_base);
  assign hit_ctl = en && (io_addr == ctl_addr);
  assign hit_bm  = bm_en && in_block(io_addr, bm_base);

  AST_CTL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (ctl_addr[1:0] == 2'b10)); // R6
  AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cmd_base[2:0] == 3'b000)); // R5
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd || hit_ctl) |-> (io_en && chan_on)); // R9
  AST_BM_HIT_NEEDS_BM_EN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bm |-> bm_en); // R9
endmodule

// File: rtl/ide_addr_decoder.sv
module ide_addr_decoder
  import ide_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [7:0]        sts_set,
  input  logic [IO_W-1:0]   io_addr,
  output logic [NCH-1:0]    ch_en,
  output logic [IO_W-1:0]   pri_cmd_base,
  output logic [IO_W-1:0]   pri_ctl_addr,
  output logic [IO_W-1:0]   sec_cmd_base,
  output logic [IO_W-1:0]   sec_ctl_addr,
  output logic [IO_W-1:0]   pri_bm_base,
  output logic [IO_W-1:0]   sec_bm_base,
  output logic              bm_en,
  output logic [NCH-1:0]    hit_cmd,
  output logic [NCH-1:0]    hit_ctl,
  output logic [NCH-1:0]    hit_bm
);
  logic [7:0]               cmd_q, pi_q, chctl_q, sts_q;
  logic [NCH-1:0][IO_W-1:0] cmd_bar_q, ctl_bar_q;
  logic [IO_W-1:0]          bm_bar_q;
  logic [NCH-1:0][IO_W-1:0] cmd_b, ctl_a, bm_b;
  logic                     io_space_en;

  ide_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sts_set   (sts_set),
    .cfg_rdata (cfg_rdata),
    .cmd_q     (cmd_q),
    .pi_q      (pi_q),
    .chctl_q   (chctl_q),
    .sts_q     (sts_q),
    .cmd_bar_q (cmd_bar_q),
    .ctl_bar_q (ctl_bar_q),
    .bm_bar_q  (bm_bar_q)
  );

  assign io_space_en = cmd_q[0];
  assign bm_en       = cmd_q[2];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ide_chan_decode #(.CH(c)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_en    (io_space_en),
      .chan_on  (chctl_q[chan_on_bit(c)]),
      .native   (pi_q[native_bit(c)]),
      .bm_en    (bm_en),
      .cmd_bar  (cmd_bar_q[c]),
      .ctl_bar  (ctl_bar_q[c]),
      .bm_bar   (bm_bar_q),
      .io_addr  (io_addr),
      .en       (ch_en[c]),
      .cmd_base (cmd_b[c]),
      .ctl_addr (ctl_a[c]),
      .bm_base  (bm_b[c]),
      .hit_cmd  (hit_cmd[c]),
      .hit_ctl  (hit_ctl[c]),
      .hit_bm   (hit_bm[c])
    );
  end

  assign pri_cmd_base = cmd_b[0];
  assign pri_ctl_addr = ctl_a[0];
  assign sec_cmd_base = cmd_b[1];
  assign sec_ctl_addr = ctl_a[1];
  assign pri_bm_base  = bm_b[0];
  assign sec_bm_base  = bm_b[1];

  AST_EN_NEEDS_IO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_en) |-> cmd_q[0]); // R2
  AST_BM_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sec_bm_base == pri_bm_base + IO_W'(BLK_SPAN)); // R7
  AST_BM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pri_bm_base[3:0] == 4'h0); // R7
  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CMD && cfg_wdata[0] == 1'b0) |=> (ch_en == '0)); // R10
endmodule

// File: tb/ide_addr_decoder_tb.sv
`timescale 1ns/1ps
module ide_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [7:0]  sts_set = 8'h00;
  logic [15:0] io_addr = 16'h0000;
  logic [1:0]  ch_en, hit_cmd, hit_ctl, hit_bm;
  logic [15:0] pri_cmd_base, pri_ctl_addr, sec_cmd_base, sec_ctl_addr, pri_bm_base, sec_bm_base;
  logic        bm_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side copy of what software has written, already masked per R3
  logic [7:0]  m_cmd, m_pi, m_ctl;
  logic [15:0] m_cbar[2], m_kbar[2], m_bbar;

  always #2.5 clk = ~clk;

  ide_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sts_set(sts_set), .io_addr(io_addr), .ch_en(ch_en),
    .pri_cmd_base(pri_cmd_base), .pri_ctl_addr(pri_ctl_addr), .sec_cmd_base(sec_cmd_base),
    .sec_ctl_addr(sec_ctl_addr), .pri_bm_base(pri_bm_base), .sec_bm_base(sec_bm_base),
    .bm_en(bm_en), .hit_cmd(hit_cmd), .hit_ctl(hit_ctl), .hit_bm(hit_bm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic exp_en(input int c);
    return m_cmd[0] && ((c == 0) ? m_ctl[2] : m_ctl[1]);
  endfunction
  function automatic logic exp_nat(input int c);
    return (c == 0) ? m_pi[0] : m_pi[2];
  endfunction
  function automatic logic [15:0] exp_cmd(input int c);
    if (exp_nat(c)) return m_cbar[c] & 16'hFFF8;
    return (c == 0) ? 16'h01F0 : 16'h0170;
  endfunction
  function automatic logic [15:0] exp_ctl(input int c);
    if (exp_nat(c)) return 16'((m_kbar[c] & 16'hFFFC) + 16'd2);
    return (c == 0) ? 16'h03F6 : 16'h0376;
  endfunction
  function automatic logic [15:0] exp_bm(input int c);
    return 16'((m_bbar & 16'hFFF0) + 16'(8 * c));
  endfunction
  function automatic logic in_rng(input logic [15:0] a, input logic [15:0] b);
    int d;
    d = int'(a) - int'(b);
    return (d >= 0) && (d <= 7);
  endfunction

  task automatic set_bars(input logic [15:0] pc, input logic [15:0] pk,
                          input logic [15:0] sc, input logic [15:0] sk, input logic [15:0] bm);
    wr(8'h10, pc[7:0]); wr(8'h11, pc[15:8]);
    wr(8'h14, pk[7:0]); wr(8'h15, pk[15:8]);
    wr(8'h18, sc[7:0]); wr(8'h19, sc[15:8]);
    wr(8'h1C, sk[7:0]); wr(8'h1D, sk[15:8]);
    wr(8'h20, bm[7:0]); wr(8'h21, bm[15:8]);
    m_cbar[0] = pc; m_kbar[0] = pk; m_cbar[1] = sc; m_kbar[1] = sk; m_bbar = bm;
  endtask

  task automatic probe(input logic [15:0] a);
    logic [5:0] e;
    io_addr = a;
    #1;
    for (int c = 0; c < 2; c++) begin
      e[c]     = exp_en(c) && in_rng(a, exp_cmd(c));
      e[2 + c] = exp_en(c) && (a == exp_ctl(c));
      e[4 + c] = m_cmd[2] && in_rng(a, exp_bm(c));
    end
    chk("R9 hits {bm,ctl,cmd}", {26'd0, hit_bm, hit_ctl, hit_cmd}, {26'd0, e});
  endtask

  task automatic check_outputs();
    chk("R2 ch_en", {30'd0, ch_en}, {30'd0, exp_en(1), exp_en(0)});
    chk("R4/R5 pri cmd", {16'd0, pri_cmd_base}, {16'd0, exp_cmd(0)});
    chk("R4/R5 sec cmd", {16'd0, sec_cmd_base}, {16'd0, exp_cmd(1)});
    chk("R4/R6 pri ctl", {16'd0, pri_ctl_addr}, {16'd0, exp_ctl(0)});
    chk("R4/R6 sec ctl", {16'd0, sec_ctl_addr}, {16'd0, exp_ctl(1)});
    chk("R7 pri bm", {16'd0, pri_bm_base}, {16'd0, exp_bm(0)});
    chk("R7 sec bm", {16'd0, sec_bm_base}, {16'd0, exp_bm(1)});
    chk("R7 bm_en", {31'd0, bm_en}, {31'd0, m_cmd[2]});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] bars[3][5];
    bars[0] = '{16'hC007, 16'hC00B, 16'hC100, 16'hFFFF, 16'hD00F};
    bars[1] = '{16'hFFFF, 16'h0001, 16'h0008, 16'hFFFD, 16'hFFFF};
    bars[2] = '{16'h01F0, 16'h03F4, 16'h0170, 16'h0374, 16'h0000};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h4A, d); chk("R1 0x4A reset", {24'd0, d}, 32'h06);
    rd(8'h04, d); chk("R1 0x04 reset", {24'd0, d}, 32'h00);
    rd(8'h07, d); chk("R1 0x07 reset", {24'd0, d}, 32'h00);
    rd(8'h09, d); chk("R1 0x09 reset", {24'd0, d}, 32'h00);
    rd(8'h11, d); chk("R1 bar reset", {24'd0, d}, 32'h00);
    rd(8'h20, d); chk("R1 bm bar reset", {24'd0, d}, 32'h00);
    chk("R1 ch_en reset", {30'd0, ch_en}, 32'd0);
    chk("R1 bm_en reset", {31'd0, bm_en}, 32'd0);

    // R3 masks
    wr(8'h04, 8'hFF); rd(8'h04, d); chk("R3 cmd mask", {24'd0, d}, 32'h05);
    wr(8'h09, 8'hFF); rd(8'h09, d); chk("R3 progif mask", {24'd0, d}, 32'hCF);
    wr(8'h4A, 8'hFF); rd(8'h4A, d); chk("R3 chctl mask", {24'd0, d}, 32'hAF);
    wr(8'h4A, 8'h50); rd(8'h4A, d); chk("R3 chctl mask 2", {24'd0, d}, 32'h00);

    // R11 unlisted offsets
    set_bars(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h4321);
    wr(8'h12, 8'hFF); wr(8'h16, 8'hFF); wr(8'h22, 8'hFF); wr(8'h4B, 8'hFF); wr(8'h05, 8'hFF);
    rd(8'h12, d); chk("R11 0x12 reads 0", {24'd0, d}, 32'h00);
    rd(8'h4B, d); chk("R11 0x4B reads 0", {24'd0, d}, 32'h00);
    rd(8'h05, d); chk("R11 0x05 reads 0", {24'd0, d}, 32'h00);
    rd(8'h11, d); chk("R11 bar hi untouched", {24'd0, d}, 32'h12);
    rd(8'h21, d); chk("R11 bm hi untouched", {24'd0, d}, 32'h43);
    rd(8'h04, d); chk("R11 cmd untouched", {24'd0, d}, 32'h05);
    rd(8'h4A, d); chk("R11 chctl untouched", {24'd0, d}, 32'h00);

    // R10 timing: old value before the capturing edge, new value after
    wr(8'h04, 8'h01); wr(8'h4A, 8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h4A; cfg_wdata = 8'h06;
    #1; chk("R10 before edge", {30'd0, ch_en}, 32'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 after edge", {30'd0, ch_en}, 32'd3);

    // R8 status
    @(negedge clk); sts_set = 8'hA5;
    @(negedge clk); sts_set = 8'h00;
    rd(8'h07, d); chk("R8 set latches", {24'd0, d}, 32'hA5);
    @(negedge clk); rd(8'h07, d); chk("R8 sticky", {24'd0, d}, 32'hA5);
    wr(8'h07, 8'h0F); rd(8'h07, d); chk("R8 and-write", {24'd0, d}, 32'h05);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h07; cfg_wdata = 8'h00; sts_set = 8'h40;
    @(negedge clk);
    cfg_we = 1'b0; sts_set = 8'h00;
    rd(8'h07, d); chk("R8 set beats clear", {24'd0, d}, 32'h40);

    // R2 R4 R5 R6 R7 R9 sweep
    for (int s = 0; s < 3; s++) begin
      set_bars(bars[s][0], bars[s][1], bars[s][2], bars[s][3], bars[s][4]);
      for (int k = 0; k < 64; k++) begin
        m_cmd = {5'd0, k[1], 1'b0, k[0]};
        m_ctl = {5'd0, k[3], k[2], 1'b0};
        m_pi  = {5'd0, k[5], 1'b0, k[4]};
        wr(8'h04, m_cmd); wr(8'h4A, m_ctl); wr(8'h09, m_pi);
        check_outputs();
        for (int c = 0; c < 2; c++) begin
          for (int o = -1; o <= 8; o++) probe(16'(int'(exp_cmd(c)) + o));
          for (int o = -1; o <= 1; o++) probe(16'(int'(exp_ctl(c)) + o));
          for (int o = -1; o <= 8; o++) probe(16'(int'(exp_bm(c)) + o));
          @(negedge clk);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule